// File: doc/BRIEF.md
# Indexed Interrupt Set/Clear Register Bank

This block holds the pending-status and enable bit arrays of an interrupt controller. It also holds a small group of host output enables. Software never writes bitmasks. It names one interrupt by writing its number to a dedicated write-to-set or write-to-clear register, and only that one bit changes. This removes read-modify-write races between agents that share the arrays.

System event inputs set pending bits on their rising edge. A host output is asserted while it is enabled and at least one interrupt is both pending and enabled. Software that enables an already enabled host output produces a one-cycle low gap, so an edge-triggered receiver sees a fresh edge.

The bus is a simple single-cycle register port: address, write strobe, write data and combinational read data. Read-only bitmap words let software and test benches observe every indexed update.

Top module: `irq_idx_regbank`

## Requirements
- R1: An indexed write takes the interrupt or host number from write-data bits 9..0; bits 31..10 have no effect.
- R2: A write to the status-clear register (offset 0x24) clears the pending bit of the named interrupt; every other pending bit is kept.
- R3: A write to the enable-set register (offset 0x28) sets the enable bit of the named interrupt only.
- R4: A write to the enable-clear register (offset 0x2C) clears the enable bit of the named interrupt only.
- R5: A write to the host-enable-set register (offset 0x34) enables the named host output, and a write to the host-enable-clear register (offset 0x38) disables it; other host enables are kept.
- R6: Reads of 0x24, 0x28, 0x2C, 0x34 and 0x38 return 0.
- R7: After reset all pending, enable and host enable bits are 0 and every host output is low.
- R8: An indexed write whose number is at or above NUM_IRQ (interrupt registers) or NUM_HOST (host registers) changes nothing.
- R9: A rising edge on `sys_evt[i]` sets pending bit i one clock later, and a held high level does not set it again after a clear. An edge in the same cycle as a software clear of that bit leaves the bit set.
- R10: `host_irq[h]` is high exactly when host enable h is set, no retrigger gap is in progress, and some interrupt is both pending and enabled.
- R11: Enabling a host output that is already enabled drives it low for the one cycle after the write, after which it follows R10 again; other host outputs are unaffected.
- R12: Read data at 0x80+4*w returns pending bits 32*w+31..32*w, at 0xC0+4*w enable bits likewise, and at 0x3C the host enables in bits NUM_HOST-1..0. Unused bits and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_evt | input | NUM_IRQ | System event lines, rising-edge sensitive |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| host_irq | output | NUM_HOST | Host interrupt outputs |

## Verification
The hardest case to reach from the ports is the race between an event edge and a software clear of the same bit. The bench raises the event line and issues the clear write in the same half cycle, with the bit already pending, so that both arrive at one clock edge. A second hard case is the retrigger gap. It only appears when an enabled host output is already high, so the bench first builds a pending-and-enabled interrupt through an event edge. It then samples the output in the cycle right after the repeated enable and once more a cycle later.

// File: rtl/irq_idx_pkg.sv
package irq_idx_pkg;

    localparam int unsigned IDX_W = 10;
    localparam int unsigned REG_W = 32;

    // Byte offsets of the register map
    localparam logic [7:0] OFS_STAT_CLR = 8'h24;
    localparam logic [7:0] OFS_EN_SET   = 8'h28;
    localparam logic [7:0] OFS_EN_CLR   = 8'h2C;
    localparam logic [7:0] OFS_HEN_SET  = 8'h34;
    localparam logic [7:0] OFS_HEN_CLR  = 8'h38;
    localparam logic [7:0] OFS_HEN_MAP  = 8'h3C;
    localparam logic [7:0] OFS_STAT_MAP = 8'h80;
    localparam logic [7:0] OFS_EN_MAP   = 8'hC0;

    // One decoded indexed write, already range checked
    typedef struct packed {
        logic             stat_clr;
        logic             en_set;
        logic             en_clr;
        logic             hen_set;
        logic             hen_clr;
        logic [IDX_W-1:0] idx;
    } idx_cmd_t;

endpackage

// File: rtl/irq_idx_decode.sv
module irq_idx_decode
    import irq_idx_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_HOST = 4,
    parameter int ADDR_W   = 8
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output idx_cmd_t          cmd
);

    localparam logic [31:0] IRQ_LIM  = 32'(NUM_IRQ);
    localparam logic [31:0] HOST_LIM = 32'(NUM_HOST);

    logic [IDX_W-1:0] idx;
    logic             irq_ok;
    logic             host_ok;

    assign idx     = wdata[IDX_W-1:0];
    assign irq_ok  = 32'(idx) < IRQ_LIM;
    assign host_ok = 32'(idx) < HOST_LIM;

    always_comb begin
        cmd     = '0;
        cmd.idx = idx;
        if (wr_en) begin
            if (addr == ADDR_W'(OFS_STAT_CLR)) cmd.stat_clr = irq_ok;
            if (addr == ADDR_W'(OFS_EN_SET))   cmd.en_set   = irq_ok;
            if (addr == ADDR_W'(OFS_EN_CLR))   cmd.en_clr   = irq_ok;
            if (addr == ADDR_W'(OFS_HEN_SET))  cmd.hen_set  = host_ok;
            if (addr == ADDR_W'(OFS_HEN_CLR))  cmd.hen_clr  = host_ok;
        end
    end

endmodule

// File: rtl/irq_state_bits.sv
module irq_state_bits
    import irq_idx_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] sys_evt,
    input  idx_cmd_t           cmd,
    output logic [NUM_IRQ-1:0] status_q,
    output logic [NUM_IRQ-1:0] enable_q
);

    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    typedef struct packed {
        logic [NUM_IRQ-1:0] status;
        logic [NUM_IRQ-1:0] enable;
        logic [NUM_IRQ-1:0] evt_prev;
    } bits_t;

    bits_t st_d, st_q;
    logic [NUM_IRQ-1:0] sel;
    logic [NUM_IRQ-1:0] rise;

    always_comb begin
        st_d          = st_q;
        sel           = ONE << cmd.idx;
        rise          = sys_evt & ~st_q.evt_prev;
        st_d.evt_prev = sys_evt;
        if (cmd.stat_clr) st_d.status = st_d.status & ~sel;
        // an event edge in the same cycle overrides the clear
        st_d.status   = st_d.status | rise;
        if (cmd.en_set)   st_d.enable = st_d.enable | sel;
        if (cmd.en_clr)   st_d.enable = st_d.enable & ~sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.status;
    assign enable_q = st_q.enable;

endmodule

// File: rtl/irq_host_gen.sv
module irq_host_gen
    import irq_idx_pkg::*;
#(
    parameter int NUM_HOST = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  idx_cmd_t            cmd,
    input  logic                any_pend,
    output logic [NUM_HOST-1:0] hen_q,
    output logic [NUM_HOST-1:0] host_irq
);

    localparam logic [NUM_HOST-1:0] ONE = NUM_HOST'(1);

    typedef struct packed {
        logic [NUM_HOST-1:0] hen;
        logic [NUM_HOST-1:0] retrig;
    } host_t;

    host_t hs_d, hs_q;
    logic [NUM_HOST-1:0] sel;

    always_comb begin
        hs_d        = hs_q;
        sel         = ONE << cmd.idx;
        hs_d.retrig = '0;
        if (cmd.hen_set) begin
            hs_d.retrig = sel & hs_q.hen;
            hs_d.hen    = hs_q.hen | sel;
        end
        if (cmd.hen_clr) hs_d.hen = hs_d.hen & ~sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign hen_q    = hs_q.hen;
    assign host_irq = hs_q.hen & ~hs_q.retrig & {NUM_HOST{any_pend}};

endmodule

// File: rtl/irq_idx_regbank.sv
module irq_idx_regbank
    import irq_idx_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_HOST = 4,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  sys_evt,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic [NUM_HOST-1:0] host_irq
);

    localparam int NWORDS = (NUM_IRQ + REG_W - 1) / REG_W;
    localparam int PAD_W  = NWORDS * REG_W;

    idx_cmd_t            cmd;
    logic [NUM_IRQ-1:0]  status_vec;
    logic [NUM_IRQ-1:0]  enable_vec;
    logic [NUM_HOST-1:0] hen_vec;
    logic [PAD_W-1:0]    stat_pad;
    logic [PAD_W-1:0]    en_pad;
    logic                any_pend;

    irq_idx_decode #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_HOST(NUM_HOST),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .wr_en(bus_wr),
        .addr (bus_addr),
        .wdata(bus_wdata),
        .cmd  (cmd)
    );

    irq_state_bits #(
        .NUM_IRQ(NUM_IRQ)
    ) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .sys_evt (sys_evt),
        .cmd     (cmd),
        .status_q(status_vec),
        .enable_q(enable_vec)
    );

    assign any_pend = |(status_vec & enable_vec);

    irq_host_gen #(
        .NUM_HOST(NUM_HOST)
    ) u_host (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd     (cmd),
        .any_pend(any_pend),
        .hen_q   (hen_vec),
        .host_irq(host_irq)
    );

    assign stat_pad = PAD_W'(status_vec);
    assign en_pad   = PAD_W'(enable_vec);

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_HEN_MAP)) bus_rdata = REG_W'(hen_vec);
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_addr == ADDR_W'(32'(OFS_STAT_MAP) + 32'(4 * w)))
                bus_rdata = stat_pad[w*REG_W +: REG_W];
            if (bus_addr == ADDR_W'(32'(OFS_EN_MAP) + 32'(4 * w)))
                bus_rdata = en_pad[w*REG_W +: REG_W];
        end
    end

endmodule

// File: rtl/irq_idx_regbank_chk.sv
module irq_idx_regbank_chk
    import irq_idx_pkg::*;
#(
    parameter int NUM_IRQ  = 64,
    parameter int NUM_HOST = 4,
    parameter int ADDR_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_IRQ-1:0]  sys_evt,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [NUM_HOST-1:0] host_irq,
    input logic [NUM_IRQ-1:0]  status_vec,
    input logic [NUM_IRQ-1:0]  enable_vec,
    input logic [NUM_HOST-1:0] hen_vec
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int HW = (NUM_HOST > 1) ? $clog2(NUM_HOST) : 1;

    logic [IW-1:0]      si;
    logic [HW-1:0]      hi;
    logic               irq_ok, host_ok;
    logic [NUM_IRQ-1:0] prev_c;
    logic [NUM_IRQ-1:0] edge_c;

    assign si      = bus_wdata[IW-1:0];
    assign hi      = bus_wdata[HW-1:0];
    assign irq_ok  = 32'(bus_wdata[IDX_W-1:0]) < 32'(NUM_IRQ);
    assign host_ok = 32'(bus_wdata[IDX_W-1:0]) < 32'(NUM_HOST);
    assign edge_c  = sys_evt & ~prev_c;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_c <= '0;
        else        prev_c <= sys_evt;
    end

    p_stat_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_STAT_CLR) && irq_ok && sys_evt == '0)
        |=> !status_vec[$past(si)]);

    p_en_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_EN_SET) && irq_ok)
        |=> enable_vec[$past(si)]);

    p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_EN_CLR) && irq_ok)
        |=> !enable_vec[$past(si)]);

    p_hen_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_HEN_SET) && host_ok)
        |=> hen_vec[$past(hi)]);

    p_rd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_STAT_CLR) || bus_addr == ADDR_W'(OFS_EN_SET) ||
         bus_addr == ADDR_W'(OFS_EN_CLR) || bus_addr == ADDR_W'(OFS_HEN_SET) ||
         bus_addr == ADDR_W'(OFS_HEN_CLR))
        |-> bus_rdata == '0);

    p_evt_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_c) |=> ((status_vec & $past(edge_c)) == $past(edge_c)));

    p_host_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|host_irq) |-> ((host_irq & ~hen_vec) == '0));

    p_host_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|host_irq) |-> (|(status_vec & enable_vec)));

    p_retrig_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_HEN_SET) && host_ok && hen_vec[hi])
        |=> !host_irq[$past(hi)]);

endmodule

bind irq_idx_regbank irq_idx_regbank_chk #(
    .NUM_IRQ (NUM_IRQ),
    .NUM_HOST(NUM_HOST),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sys_evt   (sys_evt),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .host_irq  (host_irq),
    .status_vec(status_vec),
    .enable_vec(enable_vec),
    .hen_vec   (hen_vec)
);

// File: tb/irq_idx_regbank_bench.sv
module irq_idx_regbank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_evt = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  host_irq;

    int total = 0;
    int bad = 0;

    logic [63:0] m_stat = '0;
    logic [63:0] m_en = '0;
    logic [3:0]  m_hen = '0;

    irq_idx_regbank u_irq_idx_regbank (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_evt  (sys_evt),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .host_irq (host_irq)
    );

    always #4 clk = ~clk;

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not complete act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [3:0] exp_host();
        return m_hen & {4{|(m_stat & m_en)}};
    endfunction

    task automatic chk_maps(input string req);
        logic [31:0] lo, hi, h;
        rd(8'h80, lo); rd(8'h84, hi);
        check({req, " status"}, {hi, lo}, m_stat);
        rd(8'hC0, lo); rd(8'hC4, hi);
        check({req, " enable"}, {hi, lo}, m_en);
        rd(8'h3C, h);
        check({req, " host-enable"}, 64'(h), 64'(m_hen));
    endtask

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        chk_maps("R7");
        check("R7 host_irq", 64'(host_irq), 64'd0);

        // R3 and R12: enable-set sweep
        for (int i = 0; i < 64; i++) begin
            wr(8'h28, 32'(i));
            m_en[i] = 1'b1;
            rd(8'hC0, d); check("R3 R12 enable lo", 64'(d), 64'(m_en[31:0]));
            rd(8'hC4, d); check("R3 R12 enable hi", 64'(d), 64'(m_en[63:32]));
        end

        // R6: indexed registers read zero
        rd(8'h24, d); check("R6 0x24", 64'(d), 64'd0);
        rd(8'h28, d); check("R6 0x28", 64'(d), 64'd0);
        rd(8'h2C, d); check("R6 0x2C", 64'(d), 64'd0);
        rd(8'h34, d); check("R6 0x34", 64'(d), 64'd0);
        rd(8'h38, d); check("R6 0x38", 64'(d), 64'd0);
        rd(8'h88, d); check("R12 unmapped", 64'(d), 64'd0);

        // R8: out-of-range interrupt numbers
        wr(8'h2C, 32'd64);
        wr(8'h2C, 32'd1023);
        chk_maps("R8 enable-clear range");

        // R4: clear every even enable
        for (int i = 0; i < 64; i += 2) begin
            wr(8'h2C, 32'(i));
            m_en[i] = 1'b0;
            chk_maps("R4");
        end

        // R1: upper write-data bits ignored
        wr(8'h2C, 32'hFFFF_FC01); m_en[1] = 1'b0;
        chk_maps("R1 clear");
        wr(8'h28, 32'hABCD_E402); m_en[2] = 1'b1;
        chk_maps("R1 set");

        // R9: rising edges set pending bits, one line at a time
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            sys_evt[i] = 1'b1;
            @(negedge clk);
            m_stat[i] = 1'b1;
            rd(8'h80, d); check("R9 edge lo", 64'(d), 64'(m_stat[31:0]));
            rd(8'h84, d); check("R9 edge hi", 64'(d), 64'(m_stat[63:32]));
        end

        // R2: clear odd pending bits while event lines are held high
        for (int i = 1; i < 64; i += 2) begin
            wr(8'h24, 32'(i));
            m_stat[i] = 1'b0;
            chk_maps("R2 R9 level");
        end
        wr(8'h24, 32'd100);
        chk_maps("R8 status-clear range");

        @(negedge clk);
        sys_evt = '0;
        @(negedge clk);

        // R9: event edge and clear in the same cycle, bit 4 already pending
        @(negedge clk);
        sys_evt[4] = 1'b1;
        bus_addr   = 8'h24;
        bus_wr     = 1'b1;
        bus_wdata  = 32'd4;
        @(negedge clk);
        bus_wr     = 1'b0;
        bus_wdata  = '0;
        chk_maps("R9 race");
        wr(8'h24, 32'd4); m_stat[4] = 1'b0;
        chk_maps("R2 after race");
        @(negedge clk);
        sys_evt[4] = 1'b0;

        // R10: host gating
        wr(8'h24, 32'd2); m_stat[2] = 1'b0;
        check("R10 no pending", 64'(|(m_stat & m_en)), 64'd0);
        wr(8'h34, 32'd1); m_hen[1] = 1'b1;
        chk_maps("R5 set");
        check("R10 enabled idle", 64'(host_irq), 64'(exp_host()));
        @(negedge clk);
        sys_evt[3] = 1'b1;
        @(negedge clk);
        m_stat[3] = 1'b1;
        check("R10 pending", 64'(host_irq), 64'(exp_host()));
        check("R10 pending value", 64'(host_irq), 64'h2);

        // R11: retrigger of an enabled output
        wr(8'h34, 32'd1);
        check("R11 gap", 64'(host_irq), 64'h0);
        @(negedge clk);
        check("R11 recover", 64'(host_irq), 64'h2);

        // R8: host number out of range
        wr(8'h34, 32'd4);
        chk_maps("R8 host range");
        check("R8 host_irq", 64'(host_irq), 64'h2);

        // R5: first enable of host 0 has no gap
        wr(8'h34, 32'd0); m_hen[0] = 1'b1;
        check("R5 R10 new enable", 64'(host_irq), 64'h3);
        wr(8'h34, 32'd0);
        check("R11 other output kept", 64'(host_irq), 64'h2);
        @(negedge clk);
        check("R11 recover host0", 64'(host_irq), 64'h3);

        // R10: removing the only pending-and-enabled interrupt
        wr(8'h2C, 32'd3); m_en[3] = 1'b0;
        check("R10 none enabled", 64'(host_irq), 64'(exp_host()));
        wr(8'h28, 32'd3); m_en[3] = 1'b1;
        check("R10 re-enabled", 64'(host_irq), 64'h3);

        // R5: host clear
        wr(8'h38, 32'd1); m_hen[1] = 1'b0;
        chk_maps("R5 clear");
        check("R5 host_irq after clear", 64'(host_irq), 64'h1);
        wr(8'h38, 32'd7);
        chk_maps("R8 host-clear range");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule